// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block drives a byte-level I2C master engine through whole memory-style transactions, so the host never handles bus bytes one at a time. A request gives a 7-bit device address, a memory address of zero to four bytes, a data length and a kind: random read, multi-byte write or presence probe. The sequencer then builds one command per bus byte. It waits on the engine's status flags, each wait guarded by a timeout. It streams write data in, streams read data out, and finishes with a one-cycle `done` pulse that carries a result code.

A read starts with a dummy write of the device address. The memory address bytes follow, lowest byte first. Then comes a repeated START with the read bit set, and the data bytes are read back. A write sends the device address, the memory address bytes and then the data bytes, with STOP on the last one. A probe addresses the device for reading and takes one byte, which it discards. The engine is reset when a transaction is accepted and again when it ends. Every failure aborts at once with its own code.

The controller has eight states. `S_IDLE` accepts a request and goes to `S_FINISH` when the request is rejected, or to `S_RESET_ENG` otherwise. `S_RESET_ENG` moves on to `S_WAIT_FREE`. `S_WAIT_FREE` goes to `S_ISSUE` once the bus is free, or to `S_FINISH` on timeout. `S_ISSUE` stalls until write data is present when a data byte is due. It then goes to `S_WAIT_RX` for a read byte or to `S_WAIT_TX` for any other byte. `S_WAIT_TX` goes to `S_STEP` on transmit-done with ACK. It goes to `S_FINISH` on NAK or on timeout. `S_WAIT_RX` goes to `S_STEP` on receive-full, or to `S_FINISH` on timeout. `S_STEP` advances the byte phase (device-write, address, device-read, read-data, write-data) and returns to `S_WAIT_FREE`, or goes to `S_FINISH` after the last data byte. `S_FINISH` always returns to `S_IDLE`.

Top module: `i2c_mem_seq`

## Requirements
- R1: A read issues `{dev,0}` with start=1, then the address bytes with start=0 and stop=0 (byte 0 = `req_maddr[7:0]` first), then `{dev,1}` with start=1. Each of these expects an ACK (`eng_nak`=0).
- R2: Every read command has read=1 and data 0. All read commands except the last have nak=0 and stop=0. The last has nak=1 and stop=1. Each received byte appears on `rd_data` with a `rd_valid` pulse, in order.
- R3: A write (`req_kind`=1) issues `{dev,0}` with start=1, then the address bytes, then `req_dlen` bytes taken from the write stream, with stop=1 only on the last data byte.
- R4: A probe (`req_kind`=2) issues `{dev,1}` with start=1, then one read command with nak=1 and stop=1. It ends with code 0 when the device ACKs, and it never pulses `rd_valid`.
- R5: A NAK reported with transmit-done on any transmitted byte ends the transaction with code 3, and no further command is issued.
- R6: Before every byte the sequencer waits for `eng_bus_busy`=0. If the bus is still busy after TIMEOUT_CYC cycles of waiting, the code is 6 and no command is issued.
- R7: If transmit-done is not seen within TIMEOUT_CYC cycles after a command, the code is 2. A flag that arrives in the last permitted cycle counts as success.
- R8: If receive-full is not seen within TIMEOUT_CYC cycles after a read command, the code is 4.
- R9: A read or write with `req_dlen`=0 ends with code 1 and no command.
- R10: `req_kind`=3 or `req_alen` greater than MAX_ABYTES ends with code 5 and no command. This check is made before the empty-length check.
- R11: `done` is high for exactly one cycle, with `err_code` valid in that cycle (0 = success). `eng_rst` is high in the cycle after acceptance and in the `done` cycle. `req_ready` is high only when idle.
- R12: A read with `req_alen`=0 goes straight from `{dev,0}` to the repeated START `{dev,1}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_kind | input | 2 | 0 read, 1 write, 2 probe, 3 illegal |
| req_dev | input | 7 | Device address |
| req_maddr | input | 8*MAX_ABYTES | Memory address, byte 0 sent first |
| req_alen | input | $clog2(MAX_ABYTES+1) | Number of address bytes |
| req_dlen | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Write stream data |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write byte consumed when high with `wr_valid` |
| rd_data | output | 8 | Read stream data |
| rd_valid | output | 1 | Read byte strobe |
| done | output | 1 | Transaction end pulse |
| err_code | output | 3 | Result code, valid with `done` |
| eng_rst | output | 1 | Byte engine reset |
| eng_cmd_valid | output | 1 | Command strobe to the engine |
| eng_cmd_start | output | 1 | Send START/repeated START before the byte |
| eng_cmd_stop | output | 1 | Send STOP after the byte |
| eng_cmd_read | output | 1 | Receive a byte instead of sending |
| eng_cmd_nak | output | 1 | Answer the received byte with NAK |
| eng_cmd_data | output | 8 | Byte to transmit |
| eng_flag_clr | output | 1 | Clears the engine's done flags |
| eng_bus_busy | input | 1 | Bus busy |
| eng_tx_empty | input | 1 | Transmit done flag |
| eng_nak | input | 1 | NAK received, valid with `eng_tx_empty` |
| eng_rx_full | input | 1 | Receive full flag |
| eng_rx_data | input | 8 | Received byte |

## Verification
The engine's completion flag and the timeout expiry can fall in the same cycle. When they coincide, the flag must win. The bench models the engine with a programmable response latency. It sets the transmit-done flag to arrive exactly in the last cycle the timer allows, and expects success. It then delays the flag by one more cycle and expects a transmit timeout with code 2.

// File: rtl/i2c_mem_seq_pkg.sv
package i2c_mem_seq_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_PROBE = 2'd2,
        KIND_BAD   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        PH_DEVW,
        PH_ADDR,
        PH_DEVR,
        PH_RDATA,
        PH_WDATA
    } phase_e;

    typedef enum logic [2:0] {
        ERR_OK         = 3'd0,
        ERR_EMPTY      = 3'd1,
        ERR_TX_TIMEOUT = 3'd2,
        ERR_NO_ACK     = 3'd3,
        ERR_RX_TIMEOUT = 3'd4,
        ERR_BAD_REQ    = 3'd5,
        ERR_BUS_BUSY   = 3'd6
    } err_e;

    typedef struct packed {
        logic       start;
        logic       stop;
        logic       rd;
        logic       nak;
        logic [7:0] data;
    } bytecmd_t;

endpackage

// File: rtl/i2c_mem_seq_timer.sv
module i2c_mem_seq_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

    // R7: the count restarts whenever waiting stops
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired);

endmodule

// File: rtl/i2c_mem_seq_cmdgen.sv
module i2c_mem_seq_cmdgen
    import i2c_mem_seq_pkg::*;
#(
    parameter int MAX_ABYTES = 4,
    localparam int AIW = (MAX_ABYTES > 1) ? $clog2(MAX_ABYTES) : 1
) (
    input  phase_e                  phase,
    input  logic [6:0]              dev,
    input  logic [8*MAX_ABYTES-1:0] maddr,
    input  logic [AIW-1:0]          aidx,
    input  logic                    last_byte,
    input  logic [7:0]              wdata,
    output bytecmd_t                cmd
);
    logic [7:0] abyte [MAX_ABYTES];

    for (genvar g = 0; g < MAX_ABYTES; g++) begin : g_abyte
        assign abyte[g] = maddr[8*g +: 8];
    end

    always_comb begin
        cmd = '0;
        unique case (phase)
            PH_DEVW: begin
                cmd.start = 1'b1;
                cmd.data  = {dev, 1'b0};
            end
            PH_ADDR: begin
                cmd.data = abyte[aidx];
            end
            PH_DEVR: begin
                cmd.start = 1'b1;
                cmd.data  = {dev, 1'b1};
            end
            PH_RDATA: begin
                cmd.rd   = 1'b1;
                cmd.nak  = last_byte;
                cmd.stop = last_byte;
            end
            PH_WDATA: begin
                cmd.stop = last_byte;
                cmd.data = wdata;
            end
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/i2c_mem_seq_ctrl.sv
module i2c_mem_seq_ctrl
    import i2c_mem_seq_pkg::*;
#(
    parameter int MAX_ABYTES = 4,
    parameter int LEN_W      = 8,
    localparam int AIW = (MAX_ABYTES > 1) ? $clog2(MAX_ABYTES) : 1,
    localparam int ALW = $clog2(MAX_ABYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_kind,
    input  logic [6:0]              req_dev,
    input  logic [8*MAX_ABYTES-1:0] req_maddr,
    input  logic [ALW-1:0]          req_alen,
    input  logic [LEN_W-1:0]        req_dlen,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    output logic                    rd_valid,
    output logic                    done,
    output logic [2:0]              err_code,
    output logic                    eng_rst,
    output logic                    eng_cmd_valid,
    output logic                    eng_flag_clr,
    input  logic                    eng_bus_busy,
    input  logic                    eng_tx_empty,
    input  logic                    eng_nak,
    input  logic                    eng_rx_full,
    input  bytecmd_t                cmd,
    input  logic                    tmr_expired,
    output logic                    tmr_run,
    output phase_e                  phase,
    output logic [6:0]              dev_q,
    output logic [8*MAX_ABYTES-1:0] maddr_q,
    output logic [AIW-1:0]          aidx_q,
    output logic                    last_byte
);
    typedef enum logic [2:0] {
        S_IDLE,
        S_RESET_ENG,
        S_WAIT_FREE,
        S_ISSUE,
        S_WAIT_TX,
        S_WAIT_RX,
        S_STEP,
        S_FINISH
    } state_e;

    state_e           state, state_nxt;
    err_e             err_q, err_nxt;
    kind_e            kind_q;
    logic [ALW-1:0]   alen_q;
    logic [LEN_W-1:0] remain_q;

    logic req_bad, req_empty, addr_done, issue_go;

    assign req_bad   = (kind_e'(req_kind) == KIND_BAD) || (req_alen > ALW'(MAX_ABYTES));
    assign req_empty = (kind_e'(req_kind) != KIND_PROBE) && (req_dlen == '0);
    assign last_byte = (remain_q == LEN_W'(1));
    assign addr_done = (ALW'(aidx_q) + ALW'(1)) == alen_q;
    assign issue_go  = !((phase == PH_WDATA) && !wr_valid);

    // next-state and result selection
    always_comb begin
        state_nxt = state;
        err_nxt   = err_q;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_bad) begin
                        state_nxt = S_FINISH;
                        err_nxt   = ERR_BAD_REQ;
                    end else if (req_empty) begin
                        state_nxt = S_FINISH;
                        err_nxt   = ERR_EMPTY;
                    end else begin
                        state_nxt = S_RESET_ENG;
                        err_nxt   = ERR_OK;
                    end
                end
            end
            S_RESET_ENG: state_nxt = S_WAIT_FREE;
            S_WAIT_FREE: begin
                if (!eng_bus_busy) begin
                    state_nxt = S_ISSUE;
                end else if (tmr_expired) begin
                    state_nxt = S_FINISH;
                    err_nxt   = ERR_BUS_BUSY;
                end
            end
            S_ISSUE: begin
                if (issue_go) state_nxt = cmd.rd ? S_WAIT_RX : S_WAIT_TX;
            end
            S_WAIT_TX: begin
                if (eng_tx_empty) begin
                    if (eng_nak) begin
                        state_nxt = S_FINISH;
                        err_nxt   = ERR_NO_ACK;
                    end else begin
                        state_nxt = S_STEP;
                    end
                end else if (tmr_expired) begin
                    state_nxt = S_FINISH;
                    err_nxt   = ERR_TX_TIMEOUT;
                end
            end
            S_WAIT_RX: begin
                if (eng_rx_full) begin
                    state_nxt = S_STEP;
                end else if (tmr_expired) begin
                    state_nxt = S_FINISH;
                    err_nxt   = ERR_RX_TIMEOUT;
                end
            end
            S_STEP: begin
                if (((phase == PH_RDATA) || (phase == PH_WDATA)) && last_byte)
                    state_nxt = S_FINISH;
                else
                    state_nxt = S_WAIT_FREE;
            end
            S_FINISH: state_nxt = S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    // state and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            err_q    <= ERR_OK;
            kind_q   <= KIND_READ;
            phase    <= PH_DEVW;
            dev_q    <= '0;
            maddr_q  <= '0;
            alen_q   <= '0;
            aidx_q   <= '0;
            remain_q <= '0;
        end else begin
            state <= state_nxt;
            err_q <= err_nxt;
            if (state == S_IDLE && req_valid) begin
                kind_q   <= kind_e'(req_kind);
                dev_q    <= req_dev;
                maddr_q  <= req_maddr;
                alen_q   <= req_alen;
                aidx_q   <= '0;
                phase    <= (kind_e'(req_kind) == KIND_PROBE) ? PH_DEVR : PH_DEVW;
                remain_q <= (kind_e'(req_kind) == KIND_PROBE) ? LEN_W'(1) : req_dlen;
            end else if (state == S_STEP) begin
                unique case (phase)
                    PH_DEVW: begin
                        if (alen_q != '0) phase <= PH_ADDR;
                        else phase <= (kind_q == KIND_READ) ? PH_DEVR : PH_WDATA;
                    end
                    PH_ADDR: begin
                        if (addr_done) phase <= (kind_q == KIND_READ) ? PH_DEVR : PH_WDATA;
                        else aidx_q <= aidx_q + 1'b1;
                    end
                    PH_DEVR: phase <= PH_RDATA;
                    PH_RDATA, PH_WDATA: begin
                        if (!last_byte) remain_q <= remain_q - 1'b1;
                    end
                    default: phase <= PH_DEVW;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == S_IDLE);
        done          = (state == S_FINISH);
        err_code      = err_q;
        eng_rst       = (state == S_RESET_ENG) || (state == S_FINISH);
        wr_ready      = (state == S_ISSUE) && (phase == PH_WDATA);
        eng_cmd_valid = (state == S_ISSUE) && issue_go;
        eng_flag_clr  = ((state == S_WAIT_TX) && eng_tx_empty) ||
                        ((state == S_WAIT_RX) && eng_rx_full);
        rd_valid      = (state == S_WAIT_RX) && eng_rx_full && (kind_q != KIND_PROBE);
        tmr_run       = (state == S_WAIT_FREE) || (state == S_WAIT_TX) || (state == S_WAIT_RX);
    end

    // R11: result pulse lasts one cycle and resets the engine
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_resets: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> eng_rst);
    // R2: a read command carries NAK exactly when it carries STOP
    a_r2_nak_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && cmd.rd) |-> (cmd.nak == cmd.stop));
    // R1: an addressing byte never reads and never stops
    a_r1_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd_valid && cmd.start) |-> (!cmd.rd && !cmd.stop));
    // R5: a NAK on a transmitted byte ends with the missing-ACK code
    a_r5_nak_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_TX && eng_tx_empty && eng_nak) |=> (done && err_code == 3'd3));
    // R7: a flag seen on the expiry cycle still counts as success
    a_r7_flag_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_TX && eng_tx_empty && !eng_nak && tmr_expired) |=> !done);

endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
    import i2c_mem_seq_pkg::*;
#(
    parameter int MAX_ABYTES  = 4,
    parameter int LEN_W       = 8,
    parameter int TIMEOUT_CYC = 500000,
    localparam int ALW = $clog2(MAX_ABYTES + 1),
    localparam int AIW = (MAX_ABYTES > 1) ? $clog2(MAX_ABYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_kind,
    input  logic [6:0]              req_dev,
    input  logic [8*MAX_ABYTES-1:0] req_maddr,
    input  logic [ALW-1:0]          req_alen,
    input  logic [LEN_W-1:0]        req_dlen,
    input  logic [7:0]              wr_data,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    output logic [7:0]              rd_data,
    output logic                    rd_valid,
    output logic                    done,
    output logic [2:0]              err_code,
    output logic                    eng_rst,
    output logic                    eng_cmd_valid,
    output logic                    eng_cmd_start,
    output logic                    eng_cmd_stop,
    output logic                    eng_cmd_read,
    output logic                    eng_cmd_nak,
    output logic [7:0]              eng_cmd_data,
    output logic                    eng_flag_clr,
    input  logic                    eng_bus_busy,
    input  logic                    eng_tx_empty,
    input  logic                    eng_nak,
    input  logic                    eng_rx_full,
    input  logic [7:0]              eng_rx_data
);
    bytecmd_t                cmd;
    phase_e                  phase;
    logic [6:0]              dev_q;
    logic [8*MAX_ABYTES-1:0] maddr_q;
    logic [AIW-1:0]          aidx_q;
    logic                    last_byte;
    logic                    tmr_run, tmr_expired;

    i2c_mem_seq_ctrl #(
        .MAX_ABYTES(MAX_ABYTES),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_kind     (req_kind),
        .req_dev      (req_dev),
        .req_maddr    (req_maddr),
        .req_alen     (req_alen),
        .req_dlen     (req_dlen),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .rd_valid     (rd_valid),
        .done         (done),
        .err_code     (err_code),
        .eng_rst      (eng_rst),
        .eng_cmd_valid(eng_cmd_valid),
        .eng_flag_clr (eng_flag_clr),
        .eng_bus_busy (eng_bus_busy),
        .eng_tx_empty (eng_tx_empty),
        .eng_nak      (eng_nak),
        .eng_rx_full  (eng_rx_full),
        .cmd          (cmd),
        .tmr_expired  (tmr_expired),
        .tmr_run      (tmr_run),
        .phase        (phase),
        .dev_q        (dev_q),
        .maddr_q      (maddr_q),
        .aidx_q       (aidx_q),
        .last_byte    (last_byte)
    );

    i2c_mem_seq_cmdgen #(
        .MAX_ABYTES(MAX_ABYTES)
    ) u_cmdgen (
        .phase    (phase),
        .dev      (dev_q),
        .maddr    (maddr_q),
        .aidx     (aidx_q),
        .last_byte(last_byte),
        .wdata    (wr_data),
        .cmd      (cmd)
    );

    i2c_mem_seq_timer #(
        .LIMIT(TIMEOUT_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    assign eng_cmd_start = cmd.start;
    assign eng_cmd_stop  = cmd.stop;
    assign eng_cmd_read  = cmd.rd;
    assign eng_cmd_nak   = cmd.nak;
    assign eng_cmd_data  = cmd.data;
    assign rd_data       = eng_rx_data;

endmodule

// File: tb/i2c_mem_seq_test.sv
module i2c_mem_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [6:0]  req_dev = 7'd0;
    logic [31:0] req_maddr = 32'd0;
    logic [2:0]  req_alen = 3'd0;
    logic [7:0]  req_dlen = 8'd0;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid, done;
    logic [2:0]  err_code;
    logic        eng_rst, eng_cmd_valid, eng_cmd_start, eng_cmd_stop;
    logic        eng_cmd_read, eng_cmd_nak, eng_flag_clr;
    logic [7:0]  eng_cmd_data;
    logic        eng_bus_busy = 1'b0;
    logic        tx_f = 1'b0, rx_f = 1'b0, nak_f = 1'b0;
    logic [7:0]  rxd = 8'd0;

    // engine model controls and logs
    logic        log_clr = 1'b0;
    int          tx_lat = 2, rx_lat = 3, nak_at = -1;
    int          ncmd = 0, rdi = 0, rst_cnt = 0, rdc = 0, rdv_cnt = 0;
    int          pend = 0;
    logic        pend_rd = 1'b0, pend_nak = 1'b0;
    logic [11:0] lg [0:31];
    logic [7:0]  rdbuf [0:31];
    logic [7:0]  widx = 8'd0;

    int n_chk = 0, n_bad = 0;

    i2c_mem_seq #(.MAX_ABYTES(4), .LEN_W(8), .TIMEOUT_CYC(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_dev(req_dev), .req_maddr(req_maddr),
        .req_alen(req_alen), .req_dlen(req_dlen), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done), .err_code(err_code), .eng_rst(eng_rst),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_start(eng_cmd_start),
        .eng_cmd_stop(eng_cmd_stop), .eng_cmd_read(eng_cmd_read),
        .eng_cmd_nak(eng_cmd_nak), .eng_cmd_data(eng_cmd_data),
        .eng_flag_clr(eng_flag_clr), .eng_bus_busy(eng_bus_busy),
        .eng_tx_empty(tx_f), .eng_nak(nak_f), .eng_rx_full(rx_f),
        .eng_rx_data(rxd));

    always #(CLK_PERIOD/2) clk = ~clk;

    assign wr_data = 8'h50 + widx;

    // byte engine model: flags rise a programmed number of cycles after a command
    always @(posedge clk) begin
        if (log_clr) begin
            ncmd <= 0; rdi <= 0; rst_cnt <= 0; rdc <= 0; rdv_cnt <= 0; widx <= 8'd0;
        end else begin
            if (eng_rst) rst_cnt <= rst_cnt + 1;
            if (rd_valid) begin
                if (rdc < 32) rdbuf[rdc] <= rd_data;
                rdc <= rdc + 1;
                rdv_cnt <= rdv_cnt + 1;
            end
            if (wr_valid && wr_ready) widx <= widx + 8'd1;
            if (eng_cmd_valid) begin
                if (ncmd < 32)
                    lg[ncmd] <= {eng_cmd_start, eng_cmd_stop, eng_cmd_read, eng_cmd_nak, eng_cmd_data};
                ncmd <= ncmd + 1;
            end
        end
        if (eng_rst) begin
            tx_f <= 1'b0; rx_f <= 1'b0; nak_f <= 1'b0; pend <= 0;
        end else begin
            if (eng_flag_clr) begin tx_f <= 1'b0; rx_f <= 1'b0; end
            if (eng_cmd_valid) begin
                pend     <= eng_cmd_read ? rx_lat : tx_lat;
                pend_rd  <= eng_cmd_read;
                pend_nak <= (ncmd == nak_at);
                if (eng_cmd_read) begin rxd <= 8'hC0 + 8'(rdi); rdi <= rdi + 1; end
            end else if (pend > 1) begin
                pend <= pend - 1;
            end else if (pend == 1) begin
                pend <= 0;
                if (pend_rd) rx_f <= 1'b1;
                else begin tx_f <= 1'b1; nak_f <= pend_nak; end
            end
        end
    end

    function automatic logic [11:0] mk(input logic s, input logic p, input logic r,
                                       input logic k, input logic [7:0] d);
        return {s, p, r, k, d};
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_cmd(input string req, input int i, input logic [11:0] exp);
        chk(ncmd > i && lg[i] == exp, req, $sformatf("command %0d", i), int'(lg[i]), int'(exp));
    endtask

    task automatic run_req(input logic [1:0] k, input logic [6:0] d, input logic [31:0] ma,
                           input logic [2:0] al, input logic [7:0] dl, output int code);
        bit got = 0;
        code = -1;
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
        chk(req_ready, "R11", "ready when idle", int'(req_ready), 1);
        req_kind = k; req_dev = d; req_maddr = ma; req_alen = al; req_dlen = dl;
        req_valid = 1'b1;
        @(negedge clk) req_valid = 1'b0;
        for (int n = 0; n < 3000 && !got; n++) begin
            if (done) begin got = 1; code = int'(err_code); end
            else @(negedge clk);
        end
        chk(got, "R11", "done seen", int'(got), 1);
        @(negedge clk);
        chk(!done, "R11", "done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(!done && !eng_cmd_valid && req_ready, "R11", "reset state",
            int'({done, eng_cmd_valid, req_ready}), 1);
    endtask

    task automatic t_read();
        int c;
        run_req(2'd0, 7'h50, 32'h0000_1234, 3'd2, 8'd3, c);
        chk(c == 0, "R1", "read code", c, 0);
        chk(ncmd == 7, "R1", "read command count", ncmd, 7);
        chk_cmd("R1", 0, mk(1, 0, 0, 0, 8'hA0));
        chk_cmd("R1", 1, mk(0, 0, 0, 0, 8'h34));
        chk_cmd("R1", 2, mk(0, 0, 0, 0, 8'h12));
        chk_cmd("R1", 3, mk(1, 0, 0, 0, 8'hA1));
        chk_cmd("R2", 4, mk(0, 0, 1, 0, 8'h00));
        chk_cmd("R2", 5, mk(0, 0, 1, 0, 8'h00));
        chk_cmd("R2", 6, mk(0, 1, 1, 1, 8'h00));
        chk(rdc == 3, "R2", "bytes delivered", rdc, 3);
        for (int i = 0; i < 3; i++)
            chk(rdbuf[i] == 8'hC0 + 8'(i), "R2", "read data", int'(rdbuf[i]), 'hC0 + i);
        chk(rst_cnt == 2, "R11", "engine resets", rst_cnt, 2);
    endtask

    task automatic t_write();
        int c;
        run_req(2'd1, 7'h21, 32'h0000_007F, 3'd1, 8'd2, c);
        chk(c == 0, "R3", "write code", c, 0);
        chk(ncmd == 4, "R3", "write command count", ncmd, 4);
        chk_cmd("R3", 0, mk(1, 0, 0, 0, 8'h42));
        chk_cmd("R3", 1, mk(0, 0, 0, 0, 8'h7F));
        chk_cmd("R3", 2, mk(0, 0, 0, 0, 8'h50));
        chk_cmd("R3", 3, mk(0, 1, 0, 0, 8'h51));
    endtask

    task automatic t_probe();
        int c;
        run_req(2'd2, 7'h3C, 32'd0, 3'd0, 8'd0, c);
        chk(c == 0, "R4", "probe code", c, 0);
        chk(ncmd == 2, "R4", "probe command count", ncmd, 2);
        chk_cmd("R4", 0, mk(1, 0, 0, 0, 8'h79));
        chk_cmd("R4", 1, mk(0, 1, 1, 1, 8'h00));
        chk(rdv_cnt == 0, "R4", "no read strobe", rdv_cnt, 0);
    endtask

    task automatic t_read_noaddr();
        int c;
        run_req(2'd0, 7'h11, 32'hFFFF_FFFF, 3'd0, 8'd1, c);
        chk(c == 0 && ncmd == 3, "R12", "code and count", c * 16 + ncmd, 3);
        chk_cmd("R12", 0, mk(1, 0, 0, 0, 8'h22));
        chk_cmd("R12", 1, mk(1, 0, 0, 0, 8'h23));
        chk_cmd("R12", 2, mk(0, 1, 1, 1, 8'h00));
    endtask

    task automatic t_nak();
        int c;
        nak_at = 1;
        run_req(2'd1, 7'h21, 32'h0000_BEEF, 3'd2, 8'd2, c);
        nak_at = -1;
        chk(c == 3, "R5", "missing ACK code", c, 3);
        chk(ncmd == 2, "R5", "no command after NAK", ncmd, 2);
    endtask

    task automatic t_busy();
        int c;
        eng_bus_busy = 1'b1;
        run_req(2'd2, 7'h3C, 32'd0, 3'd0, 8'd0, c);
        chk(c == 6, "R6", "bus busy code", c, 6);
        chk(ncmd == 0, "R6", "no command while busy", ncmd, 0);
        fork
            run_req(2'd2, 7'h3C, 32'd0, 3'd0, 8'd0, c);
            begin repeat (8) @(negedge clk); eng_bus_busy = 1'b0; end
        join
        chk(c == 0 && ncmd == 2, "R6", "waits then proceeds", c * 16 + ncmd, 2);
    endtask

    task automatic t_tx_edge();
        int c;
        tx_lat = LIMIT - 1;
        run_req(2'd2, 7'h3C, 32'd0, 3'd0, 8'd0, c);
        chk(c == 0, "R7", "flag on last cycle wins", c, 0);
        tx_lat = LIMIT;
        run_req(2'd2, 7'h3C, 32'd0, 3'd0, 8'd0, c);
        chk(c == 2, "R7", "transmit timeout", c, 2);
        tx_lat = 2;
    endtask

    task automatic t_rx_timeout();
        int c;
        rx_lat = LIMIT;
        run_req(2'd2, 7'h3C, 32'd0, 3'd0, 8'd0, c);
        rx_lat = 3;
        chk(c == 4, "R8", "receive timeout", c, 4);
    endtask

    task automatic t_empty();
        int c;
        run_req(2'd0, 7'h10, 32'd0, 3'd1, 8'd0, c);
        chk(c == 1 && ncmd == 0, "R9", "empty read", c * 16 + ncmd, 16);
        run_req(2'd1, 7'h10, 32'd0, 3'd1, 8'd0, c);
        chk(c == 1 && ncmd == 0, "R9", "empty write", c * 16 + ncmd, 16);
    endtask

    task automatic t_bad();
        int c;
        run_req(2'd3, 7'h10, 32'd0, 3'd1, 8'd0, c);
        chk(c == 5 && ncmd == 0, "R10", "illegal kind before empty", c * 16 + ncmd, 80);
        run_req(2'd0, 7'h10, 32'd0, 3'd5, 8'd2, c);
        chk(c == 5 && ncmd == 0, "R10", "address length too long", c * 16 + ncmd, 80);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_write();
        t_probe();
        t_read_noaddr();
        t_nak();
        t_busy();
        t_tx_edge();
        t_rx_timeout();
        t_empty();
        t_bad();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule